// File: doc/BRIEF.md
# Line-to-MSI Interrupt Redirection Controller

This block converts a set of wired interrupt lines into message-signalled interrupt write requests. Each line owns a 64-bit redirection entry, written and read through a small register port that selects the line and one 32-bit half of the entry. When a line raises an interrupt, the block shuffles that entry's bits into a 32-bit address and a 32-bit data word. It then offers the pair on a valid/ready message port, which hands over one message at a time.

Each line can be edge or level triggered, active high or active low, and masked. Level lines keep a remote-IRR flag once their message has been taken. That flag blocks any further message until an end-of-interrupt (EOI) broadcast arrives with the line's 8-bit vector. If the line is still active at that point, the block sends the message again. Pending lines are served lowest index first. The block does not interpret the destination fields; it only moves them into place.

Top module: `irq_msi_router`

## Requirements
- R1: After reset no message is offered, and every entry reads low word 0x0001_0000 (masked, everything else zero) and high word 0.
- R2: The message address is 0xFEE in bits 31:20, entry bits 63:48 in bits 19:4, entry bit 11 in bit 3, and zero in bits 2:0. The high word of an entry reads back its bits 31:16 and reads zero in bits 15:0.
- R3: Message data bits 10:0 equal entry bits 10:0, and data bit 15 equals entry bit 15. All other data bits are zero. Entry bits 7:0 are the vector.
- R4: In edge mode (entry bit 15 = 0), a line sends exactly one message for each transition into its active level. Holding the line active sends nothing more.
- R5: Entry bit 13 = 1 makes the line active low. The falling edge then fires, and a rising edge does not.
- R6: A masked line (entry bit 16 = 1) sends nothing. An edge that arrives while the line is masked is dropped and is not delivered after unmasking.
- R7: A level line (entry bit 15 = 1) sends one message when it becomes active. Once that message is accepted, entry bit 14 (remote IRR) reads 1, and no further message follows while the line stays active.
- R8: An EOI whose vector equals a level entry's bits 7:0 clears that entry's remote IRR. If the line is still active, a new message follows. An EOI with a different vector has no effect.
- R9: A level line that is active while masked sends its message once it is unmasked.
- R10: Entry bit 12 (delivery status) reads 1 while that line's message is offered and not yet accepted, and reads 0 afterwards. The offered address and data hold steady until acceptance.
- R11: When several lines are pending at once, messages go out one at a time, lowest line index first.
- R12: If an EOI for a level line arrives in the same cycle as the acceptance of that line's message, remote IRR ends up set, and no new message is sent.
- R13: Edge-mode lines never set remote IRR, and an EOI carrying their vector causes no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NPINS | Interrupt lines, synchronous to clk |
| cfg_we | input | 1 | Write strobe for the selected entry half |
| cfg_pin | input | $clog2(NPINS) | Entry select |
| cfg_hi | input | 1 | 1 selects entry bits 63:32, 0 selects bits 31:0 |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected half, combinational |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The downstream side accepts the offered message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two events can collide in one cycle on a level line: the downstream side accepting its message, and an EOI carrying the same vector. The bench holds a level message unaccepted, then raises msg_ready and eoi_valid at the same clock edge. It judges the outcome by reading back remote IRR as set, by seeing no re-sent message while the line stays active, and by seeing a message follow a later EOI. Priority ordering is provoked by activating two edge lines on the same edge. Randomly built entries check the bit placement in the address and data.

// File: rtl/irq_msi_pkg.sv
package irq_msi_pkg;

    localparam int VEC_W = 8;
    localparam logic [11:0] MSI_WINDOW = 12'hFEE;

    // writable fields of one redirection entry
    typedef struct packed {
        logic [15:0]      dest;       // entry 63:48
        logic             mask;       // entry 16
        logic             level;      // entry 15
        logic             act_low;    // entry 13
        logic             dest_mode;  // entry 11
        logic [2:0]       dlv_mode;   // entry 10:8
        logic [VEC_W-1:0] vector;     // entry 7:0
    } rte_cfg_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } msi_msg_t;

    localparam rte_cfg_t RTE_RESET = '{dest: 16'h0, mask: 1'b1, level: 1'b0,
                                       act_low: 1'b0, dest_mode: 1'b0,
                                       dlv_mode: 3'b0, vector: '0};

    function automatic msi_msg_t build_msg(rte_cfg_t c);
        msi_msg_t m;
        m.addr = {MSI_WINDOW, c.dest, c.dest_mode, 3'b000};
        m.data = {16'h0, c.level, 4'h0, c.dlv_mode, c.vector};
        return m;
    endfunction

    function automatic logic [31:0] read_lo(rte_cfg_t c, logic rirr, logic dstat);
        return {15'h0, c.mask, c.level, rirr, c.act_low, dstat,
                c.dest_mode, c.dlv_mode, c.vector};
    endfunction

    function automatic logic [31:0] read_hi(rte_cfg_t c);
        return {c.dest, 16'h0};
    endfunction

    function automatic rte_cfg_t write_lo(rte_cfg_t c, logic [31:0] w);
        rte_cfg_t n = c;
        n.mask      = w[16];
        n.level     = w[15];
        n.act_low   = w[13];
        n.dest_mode = w[11];
        n.dlv_mode  = w[10:8];
        n.vector    = w[7:0];
        return n;
    endfunction

endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
    import irq_msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [31:0]      wdata,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             accept,
    input  logic             inflight,
    output logic             req,
    output msi_msg_t         msg,
    output logic [31:0]      rd_lo,
    output logic [31:0]      rd_hi
);

    rte_cfg_t cfg;
    logic     prev_act;
    logic     pend;
    logic     rirr;
    logic     act;
    logic     eoi_hit;

    assign act     = line ^ cfg.act_low;
    assign eoi_hit = eoi_valid && cfg.level && (eoi_vector == cfg.vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= RTE_RESET;
            prev_act <= 1'b0;
            pend     <= 1'b0;
            rirr     <= 1'b0;
        end else begin
            if (we_lo) cfg <= write_lo(cfg, wdata);
            if (we_hi) cfg.dest <= wdata[31:16];
            prev_act <= act;
            // edge capture; dropped while masked or in level mode
            if (cfg.level || cfg.mask) begin
                pend <= 1'b0;
            end else begin
                if (accept) pend <= 1'b0;
                if (act && !prev_act) pend <= 1'b1;
            end
            // remote IRR: acceptance wins over a same-cycle EOI
            if (!cfg.level)   rirr <= 1'b0;
            else if (accept)  rirr <= 1'b1;
            else if (eoi_hit) rirr <= 1'b0;
        end
    end

    assign req   = !cfg.mask && (cfg.level ? (act && !rirr) : pend);
    assign msg   = build_msg(cfg);
    assign rd_lo = read_lo(cfg, rirr, inflight);
    assign rd_hi = read_hi(cfg);

    // R12
    accept_sets_irr_chk: assert property (@(posedge clk) disable iff (rst)
        accept && cfg.level |=> rirr);

    // R8
    eoi_clears_irr_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_hit && !accept && !we_lo |=> !rirr);

endmodule

// File: rtl/irq_msi_arb.sv
module irq_msi_arb
    import irq_msi_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] req,
    input  msi_msg_t         msgs [NPINS],
    input  logic             msg_ready,
    output logic             msg_valid,
    output msi_msg_t         msg_out,
    output logic [NPINS-1:0] accept,
    output logic [NPINS-1:0] busy
);

    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [IW-1:0] owner;
    logic [IW-1:0] pick;
    logic          found;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                pick  = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            owner     <= '0;
            msg_out   <= '0;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end else if (!msg_valid && found) begin
            msg_valid <= 1'b1;
            owner     <= pick;
            msg_out   <= msgs[pick];
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_own
        assign busy[g]   = msg_valid && (owner == IW'(g));
        assign accept[g] = busy[g] && msg_ready;
    end

    // R10
    hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_out));

    // R11
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy));

endmodule

// File: rtl/irq_msi_router.sv
module irq_msi_router
    import irq_msi_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPINS-1:0]         irq_in,
    input  logic                     cfg_we,
    input  logic [$clog2(NPINS)-1:0] cfg_pin,
    input  logic                     cfg_hi,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic                     eoi_valid,
    input  logic [7:0]               eoi_vector,
    output logic                     msg_valid,
    input  logic                     msg_ready,
    output logic [31:0]              msg_addr,
    output logic [31:0]              msg_data
);

    logic [NPINS-1:0] req;
    logic [NPINS-1:0] accept;
    logic [NPINS-1:0] busy;
    msi_msg_t         msgs  [NPINS];
    logic [31:0]      rd_lo [NPINS];
    logic [31:0]      rd_hi [NPINS];
    msi_msg_t         msg_out;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        irq_pin_ctl pin_i (
            .clk        (clk),
            .rst        (rst),
            .line       (irq_in[g]),
            .we_lo      (cfg_we && !cfg_hi && (cfg_pin == g)),
            .we_hi      (cfg_we && cfg_hi && (cfg_pin == g)),
            .wdata      (cfg_wdata),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .accept     (accept[g]),
            .inflight   (busy[g]),
            .req        (req[g]),
            .msg        (msgs[g]),
            .rd_lo      (rd_lo[g]),
            .rd_hi      (rd_hi[g])
        );
    end

    irq_msi_arb #(.NPINS(NPINS)) arb_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .msgs      (msgs),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_out   (msg_out),
        .accept    (accept),
        .busy      (busy)
    );

    assign cfg_rdata = cfg_hi ? rd_hi[cfg_pin] : rd_lo[cfg_pin];
    assign msg_addr  = msg_out.addr;
    assign msg_data  = msg_out.data;

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> msg_addr[31:20] == 12'hFEE && msg_addr[2:0] == 3'b000);

endmodule

// File: tb/irq_msi_router_tb_top.sv
module irq_msi_router_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  irq_in;
    logic        cfg_we;
    logic [2:0]  cfg_pin;
    logic        cfg_hi;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        eoi_valid;
    logic [7:0]  eoi_vector;
    logic        msg_valid;
    logic        msg_ready;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_msi_router #(.NPINS(8)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
        .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [31:0] exp_addr(logic [31:0] lo, logic [31:0] hi);
        return {12'hFEE, hi[31:16], lo[11], 3'b000};
    endfunction

    function automatic logic [31:0] exp_data(logic [31:0] lo);
        return {16'h0, lo[15], 4'h0, lo[10:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int pin, bit hi, logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pin = 3'(pin); cfg_hi = hi; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(int pin, bit hi, output logic [31:0] val);
        cfg_pin = 3'(pin); cfg_hi = hi;
        #1 val = cfg_rdata;
    endtask

    task automatic take_msg(int lim, int hold, output logic got,
                            output logic [31:0] a, output logic [31:0] d);
        got = 1'b0; a = '0; d = '0;
        for (int i = 0; i < lim && !got; i++) begin
            @(negedge clk);
            if (msg_valid) begin got = 1'b1; a = msg_addr; d = msg_data; end
        end
        if (got) begin
            repeat (hold) @(negedge clk);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    task automatic expect_none(string tag, int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen++;
        end
        check(tag, seen, 0);
    endtask

    task automatic eoi(logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic        got;
        logic [31:0] a, d, v, lo, hi;

        rst = 1'b1; irq_in = '0; cfg_we = 1'b0; cfg_pin = '0; cfg_hi = 1'b0;
        cfg_wdata = '0; eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 valid", {31'h0, msg_valid}, 32'h0);
        for (int p = 0; p < 8; p++) begin
            rd(p, 0, v); check("R1 lo", v, 32'h0001_0000);
            rd(p, 1, v); check("R1 hi", v, 32'h0);
        end

        // R4 edge fire, R2/R3 formats
        wr(2, 1, 32'h1234_ABCD);
        wr(2, 0, 32'h0000_0A42);
        rd(2, 1, v); check("R2 hi readback", v, 32'h1234_0000);
        @(negedge clk); irq_in[2] = 1'b1;
        take_msg(10, 0, got, a, d);
        check("R4 edge fired", {31'h0, got}, 32'h1);
        check("R2 addr", a, 32'hFEE1_2348);
        check("R3 data", d, 32'h0000_0242);
        expect_none("R4 held line", 8);
        // R13 edge pin and EOI
        rd(2, 0, v); check("R13 no irr", v, 32'h0000_0A42);
        eoi(8'h42);
        expect_none("R13 eoi on edge pin", 6);
        irq_in[2] = 1'b0;

        // R5 active low
        irq_in[4] = 1'b1;
        repeat (2) @(negedge clk);
        wr(4, 0, 32'h0000_2055);
        expect_none("R5 inactive high", 4);
        irq_in[4] = 1'b0;
        take_msg(10, 0, got, a, d);
        check("R5 falling fired", {31'h0, got}, 32'h1);
        check("R5 data", d, 32'h0000_0055);
        irq_in[4] = 1'b1;
        expect_none("R5 rising ignored", 6);

        // R6 masked edge dropped
        wr(1, 0, 32'h0001_0011);
        irq_in[1] = 1'b1;
        expect_none("R6 masked", 6);
        irq_in[1] = 1'b0;
        wr(1, 0, 32'h0000_0011);
        expect_none("R6 dropped edge", 6);

        // R9 level active while masked, then unmasked
        wr(1, 0, 32'h0001_8011);
        irq_in[1] = 1'b1;
        expect_none("R6 masked level", 6);
        wr(1, 0, 32'h0000_8011);
        take_msg(10, 1, got, a, d);
        check("R9 unmask fires", {31'h0, got}, 32'h1);
        check("R3 level data", d, 32'h0000_8011);
        // R7 remote IRR
        rd(1, 0, v); check("R7 irr set", v, 32'h0000_C011);
        expect_none("R7 held level", 8);
        // R8 EOI
        eoi(8'h12);
        expect_none("R8 other vector", 6);
        rd(1, 0, v); check("R8 irr kept", v, 32'h0000_C011);
        eoi(8'h11);
        take_msg(10, 0, got, a, d);
        check("R8 refire", {31'h0, got}, 32'h1);
        check("R8 refire data", d, 32'h0000_8011);
        irq_in[1] = 1'b0;
        eoi(8'h11);
        expect_none("R8 line low", 6);
        rd(1, 0, v); check("R8 irr cleared", v, 32'h0000_8011);

        // R10 delivery status
        wr(6, 0, 32'h0000_0066);
        irq_in[6] = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 offered", {31'h0, msg_valid}, 32'h1);
        rd(6, 0, v); check("R10 dstat set", v, 32'h0000_1066);
        take_msg(2, 0, got, a, d);
        rd(6, 0, v); check("R10 dstat clear", v, 32'h0000_0066);
        irq_in[6] = 1'b0;

        // R11 priority
        wr(3, 0, 32'h0000_0033);
        wr(5, 0, 32'h0000_0035);
        @(negedge clk); irq_in[3] = 1'b1; irq_in[5] = 1'b1;
        take_msg(10, 0, got, a, d);
        check("R11 first", d, 32'h0000_0033);
        take_msg(10, 0, got, a, d);
        check("R11 second", d, 32'h0000_0035);
        irq_in[3] = 1'b0; irq_in[5] = 1'b0;

        // R12 EOI in the acceptance cycle
        wr(7, 0, 32'h0000_8077);
        irq_in[7] = 1'b1;
        got = 1'b0;
        for (int i = 0; i < 10 && !got; i++) begin
            @(negedge clk);
            got = msg_valid;
        end
        check("R12 offered", {31'h0, got}, 32'h1);
        eoi_valid = 1'b1; eoi_vector = 8'h77; msg_ready = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0; msg_ready = 1'b0;
        rd(7, 0, v); check("R12 irr set", v, 32'h0000_C077);
        expect_none("R12 no refire", 6);
        eoi(8'h77);
        take_msg(10, 0, got, a, d);
        check("R12 later eoi refires", {31'h0, got}, 32'h1);
        irq_in[7] = 1'b0;
        eoi(8'h77);

        // random entries: R2 R3 R4
        for (int p = 0; p < 8; p++) wr(p, 0, 32'h0001_0000);
        irq_in = '0;
        repeat (3) @(negedge clk);
        for (int it = 0; it < 24; it++) begin
            int p;
            p  = int'($urandom(32'd7 + it) % 8);
            lo = $urandom() & 32'h0000_0FFF;
            hi = $urandom();
            wr(p, 1, hi);
            wr(p, 0, lo);
            rd(p, 1, v); check("R2 rand hi", v, hi & 32'hFFFF_0000);
            @(negedge clk); irq_in[p] = 1'b1;
            @(negedge clk); irq_in[p] = 1'b0;
            take_msg(10, int'($urandom() % 4), got, a, d);
            check("R4 rand fired", {31'h0, got}, 32'h1);
            check("R2 rand addr", a, exp_addr(lo, hi));
            check("R3 rand data", d, exp_data(lo));
            wr(p, 0, 32'h0001_0000);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule